// File: doc/BRIEF.md
# UART register bank with interrupts

This block is the software-facing register file of a serial port. A simple word-indexed bus reaches the data, receive-status, flag, divisor, line-control, control, level-select, interrupt mask, raw status, masked status and clear registers, plus eight fixed identification bytes at the top of the index space. Transmission takes no time here. A write to the data register puts the byte on a byte-stream output in the same cycle.

Received bytes come from a byte-stream input, or from the transmit path when loopback is on. They enter a receive FIFO submodule, and reads of the data register pop them. The block keeps a raw interrupt vector, combines it with the mask, and drives one interrupt line. Read data is registered: it appears on `rd_data` after the clock edge that samples the read.

Top module: `uart_regbank`

## Requirements
- R1: After reset the level-select register (index 0x0D) reads 0x12 and every other writable register reads 0. The flag register (index 0x06) reads 0x90, the raw status reads 0 and `irq` is low.
- R2: Writes are masked. The fractional divisor (0x0A) keeps 6 bits, line control (0x0B) keeps 8 bits, control (0x0C) is ANDed with 0xFFC7, the mask (0x0E) keeps 11 bits and level select keeps 6 bits. The integer divisor (0x09) keeps all 16 bits.
- R3: Writes to the flag (0x06), raw status (0x0F) and masked status (0x10) indices change nothing. Reads of the clear index (0x11) and of unassigned indices return 0.
- R4: Any write to the receive-status register (0x01) clears it. A push into a full receive FIFO is dropped and sets the overrun flag, which is bit 3 of receive status.
- R5: A write to the clear index (0x11) clears every raw status bit that is 1 in the written value.
- R6: The masked status (0x10) reads as the raw status ANDed with the mask. `irq` is high exactly when that AND is nonzero, and it follows every access one cycle later.
- R7: A write to the data index (0x00) drives `tx_valid` high with `tx_byte` equal to bits 7:0 in that same cycle. It also sets the transmit interrupt, raw status bit 5.
- R8: When control bit 7 is set, a data write also pushes the byte into the receive FIFO. When that bit is clear, no byte is pushed.
- R9: A data read pops the oldest byte into bits 7:0 and returns the receive status in bits 15:8. A read of an empty FIFO returns 0 in bits 7:0.
- R10: The flag register always has bit 7 set. Bit 6 is set when the FIFO holds DEPTH bytes and bit 4 is set when it is empty.
- R11: Indices 0x3F8 to 0x3FF read 0x11, 0x10, 0x24, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R12: Level-select bits 5:3 choose a trigger level: 0 gives DEPTH/8, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives 3·DEPTH/4, 4 gives 7·DEPTH/8, and any other value gives DEPTH. A push that raises the count from below the level to the level or above sets raw bit 4. Any accepted push sets raw bit 6. A data read that leaves the count below the level clears bit 4, and one that empties the FIFO clears bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_idx | input | IDX_W | Word index |
| bus_wdata | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| rx_push | input | 1 | External received byte strobe |
| rx_byte | input | 8 | External received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt output |

## Verification
The receive path is first driven with external pushes that stop one short of the trigger level and then reach it. This shows whether the receive interrupt fires on crossing the level rather than on any data, while the timeout bit already follows the first byte. Loopback writes are then used to fill the FIFO past capacity, which brings out the full flag and the overrun flag and shows that the extra byte is dropped. A final run at a smaller level-select value shows that the threshold follows the register. Mask, clear and masked-status accesses are interleaved, so that the raw state, the masked view and `irq` can be told apart.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int IX_DATA  = 'h00;
  localparam int IX_RSR   = 'h01;
  localparam int IX_FLAG  = 'h06;
  localparam int IX_IDIV  = 'h09;
  localparam int IX_FDIV  = 'h0A;
  localparam int IX_LINE  = 'h0B;
  localparam int IX_CTRL  = 'h0C;
  localparam int IX_LVL   = 'h0D;
  localparam int IX_MASK  = 'h0E;
  localparam int IX_RAW   = 'h0F;
  localparam int IX_MSK   = 'h10;
  localparam int IX_CLR   = 'h11;

  localparam int BIT_RX   = 4;
  localparam int BIT_TX   = 5;
  localparam int BIT_RT   = 6;
  localparam int BIT_OVR  = 3;
  localparam int BIT_LOOP = 7;

  // receive trigger level from level-select bits 5:3
  function automatic int rx_trigger(input logic [2:0] sel, input int depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth;
    endcase
  endfunction

  // identification bytes at the top eight indices
  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h24;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq #(
  parameter int NB = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic [NB-1:0] clr_vec,
  input  logic          icr_we,
  input  logic [NB-1:0] icr_val,
  input  logic [NB-1:0] mask,
  output logic [NB-1:0] raw,
  output logic          irq
);
  logic [NB-1:0] wipe;

  assign wipe = clr_vec | (icr_we ? icr_val : '0);
  assign irq  = |(raw & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~wipe) | set_vec;
  end

  p_icr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    icr_we |=> ((raw & $past(icr_val) & ~$past(set_vec)) == '0));
  p_tx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[uart_rb_pkg::BIT_TX] |=> raw[uart_rb_pkg::BIT_TX]);
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NB   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    rd_data,
  input  logic             rx_push,
  input  logic [7:0]       rx_byte,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             irq
);
  localparam logic [IDX_W-1:0] ID_BASE = IDX_W'((1 << IDX_W) - 8);

  logic [15:0] idiv, ctrl;
  logic [5:0]  fdiv, lvl_sel;
  logic [7:0]  line, rsr;
  logic [NB-1:0] mask, raw, set_vec, clr_vec;

  logic we, re;
  logic lb_push, fifo_push, pop, push_ok, pop_ok, overrun;
  logic [7:0] push_data, head;
  logic [CW-1:0] count, cnt_n, level;
  logic full, empty;
  logic [DW-1:0] rd_next;

  function automatic logic hit(input logic [IDX_W-1:0] idx, input int k);
    return idx == IDX_W'(k);
  endfunction

  assign we = bus_sel && bus_wr;
  assign re = bus_sel && !bus_wr;

  // transmit path and loopback
  assign tx_valid  = we && hit(bus_idx, IX_DATA);
  assign tx_byte   = bus_wdata[7:0];
  assign lb_push   = tx_valid && ctrl[BIT_LOOP];
  assign fifo_push = lb_push || rx_push;
  assign push_data = lb_push ? bus_wdata[7:0] : rx_byte;
  assign pop       = re && hit(bus_idx, IX_DATA);

  uart_rb_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(push_data),
    .pop(pop), .head(head), .count(count), .full(full), .empty(empty)
  );

  // receive interrupt events
  assign push_ok = fifo_push && !full;
  assign pop_ok  = pop && !empty;
  assign overrun = fifo_push && full;
  assign cnt_n   = count + CW'(push_ok) - CW'(pop_ok);
  assign level   = CW'(rx_trigger(lvl_sel[5:3], DEPTH));

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[BIT_TX] = tx_valid;
    set_vec[BIT_RX] = push_ok && (count < level) && (cnt_n >= level);
    set_vec[BIT_RT] = push_ok;
    clr_vec[BIT_RX] = pop && (cnt_n < level);
    clr_vec[BIT_RT] = pop && (cnt_n == '0);
  end

  uart_rb_irq #(.NB(NB)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .icr_we(we && hit(bus_idx, IX_CLR)), .icr_val(bus_wdata[NB-1:0]),
    .mask(mask), .raw(raw), .irq(irq)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idiv <= '0; fdiv <= '0; line <= '0; ctrl <= '0;
      lvl_sel <= 6'h12; mask <= '0; rsr <= '0;
    end else begin
      if (we) begin
        if (hit(bus_idx, IX_IDIV)) idiv    <= bus_wdata[15:0];
        if (hit(bus_idx, IX_FDIV)) fdiv    <= bus_wdata[5:0];
        if (hit(bus_idx, IX_LINE)) line    <= bus_wdata[7:0];
        if (hit(bus_idx, IX_CTRL)) ctrl    <= bus_wdata[15:0] & 16'hFFC7;
        if (hit(bus_idx, IX_LVL))  lvl_sel <= bus_wdata[5:0];
        if (hit(bus_idx, IX_MASK)) mask    <= bus_wdata[NB-1:0];
      end
      if (we && hit(bus_idx, IX_RSR)) rsr <= '0;
      else if (overrun)               rsr[BIT_OVR] <= 1'b1;
      else if (pop)                   rsr <= rsr & 8'h08;
    end
  end

  // read multiplexer
  always_comb begin
    rd_next = '0;
    if (bus_idx >= ID_BASE) rd_next = DW'(id_byte(bus_idx[2:0]));
    else begin
      case (int'(bus_idx))
        IX_DATA: rd_next = DW'({rsr, pop_ok ? head : 8'h00});
        IX_RSR:  rd_next = DW'(rsr);
        IX_FLAG: rd_next = DW'({1'b1, full, 1'b0, empty, 4'h0});
        IX_IDIV: rd_next = DW'(idiv);
        IX_FDIV: rd_next = DW'(fdiv);
        IX_LINE: rd_next = DW'(line);
        IX_CTRL: rd_next = DW'(ctrl);
        IX_LVL:  rd_next = DW'(lvl_sel);
        IX_MASK: rd_next = DW'(mask);
        IX_RAW:  rd_next = DW'(raw);
        IX_MSK:  rd_next = DW'(raw & mask);
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_data <= '0;
    else if (re) rd_data <= rd_next;
  end

  p_rsr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit(bus_idx, IX_RSR)) |=> (rsr == '0));
  p_overrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(we && hit(bus_idx, IX_RSR))) |=> rsr[BIT_OVR]);
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_loop_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !ctrl[BIT_LOOP] && !rx_push) |=> $stable(count));
endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0] bus_idx = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rd_data;
  logic rx_push = 1'b0;
  logic [7:0] rx_byte = '0;
  logic tx_valid, irq;
  logic [7:0] tx_byte;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq)
  );

  typedef struct { logic [15:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];
  logic capt = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard
  always @(posedge clk) capt <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (capt) begin
      if (sb.size() == 0) chk("scoreboard empty", 16'h0, 16'h1);
      else begin
        rd_item_t it;
        it = sb.pop_front();
        chk(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic rd(input int idx, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_idx = 10'(idx);
    sb.push_back('{exp, tag});
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input int idx, input logic [15:0] val);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_idx = 10'(idx); bus_wdata = val;
    #1;
    if (idx == 0) begin
      chk("R7 tx_valid", 16'(tx_valid), 16'h1);
      chk("R7 tx_byte", 16'(tx_byte), 16'(val[7:0]));
    end else if (tx_valid) chk("R7 tx_valid on non-data write", 16'h1, 16'h0);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq after reset", 16'(irq), 16'h0);
    rd('h0D, 16'h0012, "R1 level select reset");
    rd('h06, 16'h0090, "R1 flags reset");
    rd('h0F, 16'h0000, "R1 raw status reset");
    rd('h0C, 16'h0000, "R1 control reset");
    // R2 write masks
    wr('h0A, 16'hFFFF); rd('h0A, 16'h003F, "R2 fractional divisor");
    wr('h0B, 16'hFFFF); rd('h0B, 16'h00FF, "R2 line control");
    wr('h0C, 16'hFF7F); rd('h0C, 16'hFF47, "R2 control");
    wr('h0E, 16'hFFFF); rd('h0E, 16'h07FF, "R2 mask");
    wr('h0D, 16'hFFFF); rd('h0D, 16'h003F, "R2 level select");
    wr('h09, 16'h1234); rd('h09, 16'h1234, "R2 integer divisor");
    wr('h0C, 16'h0000); wr('h0E, 16'h0000); wr('h0D, 16'h0012);
    // R3 ignored writes and zero reads
    wr('h06, 16'hFFFF); wr('h0F, 16'hFFFF); wr('h10, 16'hFFFF);
    rd('h06, 16'h0090, "R3 flags after write");
    rd('h0F, 16'h0000, "R3 raw after write");
    rd('h10, 16'h0000, "R3 masked after write");
    rd('h11, 16'h0000, "R3 clear reads zero");
    rd('h05, 16'h0000, "R3 unassigned reads zero");
    // R11 identification bytes
    begin
      logic [7:0] ids [8] = '{8'h11, 8'h10, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int k = 0; k < 8; k++) rd('h3F8 + k, 16'(ids[k]), "R11 id byte");
    end
    // R7 transmit, R8 no loopback, R6 masking, R5 clear
    wr('h00, 16'h00A5);
    rd('h0F, 16'h0020, "R7 tx raw bit");
    chk("R6 irq masked off", 16'(irq), 16'h0);
    rd('h06, 16'h0090, "R8 no push without loopback");
    wr('h0E, 16'h0020);
    chk("R6 irq on", 16'(irq), 16'h1);
    rd('h10, 16'h0020, "R6 masked status");
    wr('h11, 16'h0020);
    chk("R5 irq after clear", 16'(irq), 16'h0);
    rd('h0F, 16'h0000, "R5 raw after clear");
    // R12 external pushes around level 8
    for (int k = 0; k < 7; k++) push(8'(8'h10 + k));
    rd('h0F, 16'h0040, "R12 below level");
    push(8'h17);
    rd('h0F, 16'h0050, "R12 level reached");
    rd('h00, 16'h0010, "R9 first byte");
    rd('h0F, 16'h0040, "R12 rx cleared below level");
    for (int k = 1; k < 8; k++) rd('h00, 16'(8'h10 + k), "R9 fifo order");
    rd('h0F, 16'h0000, "R12 timeout cleared on empty");
    rd('h00, 16'h0000, "R9 empty read");
    // R8 loopback, R10 full, R4 overrun
    wr('h0C, 16'h0080);
    for (int k = 0; k < 16; k++) wr('h00, 16'(k));
    wr('h00, 16'h0099);
    rd('h06, 16'h00C0, "R10 full flag");
    rd('h0F, 16'h0070, "R8 loopback raw status");
    rd('h01, 16'h0008, "R4 overrun set");
    rd('h00, 16'h0800, "R9 status in upper byte");
    wr('h01, 16'h0000);
    rd('h01, 16'h0000, "R4 write clears status");
    wr('h11, 16'h0010);
    rd('h0F, 16'h0060, "R5 partial clear");
    for (int k = 1; k < 16; k++) rd('h00, 16'(k), "R8 looped byte");
    rd('h0F, 16'h0020, "R12 drained");
    chk("R6 irq tx pending", 16'(irq), 16'h1);
    wr('h11, 16'h07FF);
    chk("R6 irq after full clear", 16'(irq), 16'h0);
    // R12 level select 0 gives level 2
    wr('h0C, 16'h0000);
    wr('h0D, 16'h0000);
    push(8'h30);
    rd('h0F, 16'h0040, "R12 sel0 one byte");
    push(8'h31);
    rd('h0F, 16'h0050, "R12 sel0 level two");
    wr('h0E, 16'h0010);
    chk("R6 irq on rx", 16'(irq), 16'h1);
    rd('h00, 16'h0030, "R9 byte after level change");
    rd('h0F, 16'h0040, "R12 sel0 below level");
    chk("R6 irq off after pop", 16'(irq), 16'h0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule